// File: doc/BRIEF.md
# Flow-Controlled Boot Stream Sender

This block sits on the host side of a serial boot link. It takes a boot image one byte at a time from a valid/ready stream and sends each byte as an asynchronous serial word on a single TX line. The bit period comes from a programmable clock divider. A start command opens a session. The session closes when the byte flagged as last has gone out in full. `busy` and `done` report where the session stands.

The slave can stop the flow in two ways. One is a host-wait line whose active level is set by configuration. The other is the slave UART's active-low request-to-send output, which this block receives as a clear-to-send input. Both inputs are resynchronised before use. A pause is honoured only at a word boundary: the word being shifted always completes, and no new word starts while either pause is active. The host-wait check can be switched off, which leaves the CTS handshake as the only pause source. For half-duplex links, an optional guard gap of one full word time can be inserted after a pause ends, before the next word is sent.

Top module: `boot_stream_tx`

## Requirements
- R1: After reset, `txd` is high (idle) and `busy`, `done` and `s_ready` are all low.
- R2: Each byte is sent as one start bit (0), then eight data bits with the LSB first, then one stop bit (1). Each bit lasts `baud_div` clock cycles, and a value of 0 is treated as 1. When nothing pauses the stream, consecutive word start bits are exactly 10*`baud_div`+1 cycles apart.
- R3: A one-cycle `start` pulse while idle sets `busy` and clears `done`. `busy` stays high until the stop bit of the byte accepted with `s_last`=1 completes, and `done` then stays high until the next accepted `start`. A `start` pulse during a session has no effect.
- R4: `s_ready` is high only during a session when no word is being shifted, neither pause is active and no guard gap is pending.
- R5: When host-wait becomes active during a word, that word completes intact and no further start bit appears until host-wait is inactive again. Host-wait and CTS each pass through a two-flop synchronizer, and both read as active out of reset.
- R6: `hwait_pol`=1 makes host-wait active when `hwait_in` is high, and `hwait_pol`=0 makes it active when `hwait_in` is low.
- R7: With `hwait_en`=0, host-wait has no effect and an active level on `hwait_in` does not stop a word from being sent.
- R8: `cts_n` high pauses the stream: the current word finishes and the line stays idle until `cts_n` returns low.
- R9: With `guard_en`=1, once a pause ends at least 10*`baud_div` idle cycles pass before the next start bit. With `guard_en`=0, the next word starts within fewer cycles than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to open a session |
| busy | output | 1 | Session in progress |
| done | output | 1 | Last byte fully sent; held until the next start |
| s_data | input | 8 | Byte to send |
| s_valid | input | 1 | `s_data` is valid |
| s_last | input | 1 | This byte ends the image |
| s_ready | output | 1 | Byte accepted at this edge when `s_valid` is also high |
| baud_div | input | DIV_W | Clock cycles per bit |
| hwait_en | input | 1 | Enable the host-wait pause |
| hwait_pol | input | 1 | Active level of `hwait_in` |
| hwait_in | input | 1 | Host-wait line from the slave |
| cts_n | input | 1 | Active-low clear-to-send from the slave |
| guard_en | input | 1 | Insert a one-word guard gap after each pause |
| txd | output | 1 | Serial output, idle high |

## Verification
The bench decodes `txd` itself by sampling at mid-bit. It raises each pause partway through a word and then checks three things: the word decodes intact, no start bit appears during a long hold, and sending resumes after release. A design that cut the word short would show a framing or data error. A design that ignored the pause would show an extra start bit. Inverted polarity and a disabled host-wait are covered by sessions that would stall or run when they should not. The guard gap is checked by measuring cycles from release to the next start bit, with the gap on and with it off. A bit counter off by one shows up as a wrong start-to-start spacing during streaming.

// File: rtl/boot_stream_tx.sv
module boot_stream_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             hwait_en,
  input  logic             hwait_pol,
  input  logic             hwait_in,
  input  logic             cts_n,
  input  logic             guard_en,
  output logic             txd
);
  localparam int FRAME_BITS = 10;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {S_OFF, S_RDY, S_SEND, S_GAP} st_t;
  st_t st;

  logic [1:0] hw_sync, cts_sync;
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0] bit_idx;
  logic [DIV_W-1:0] baud_cnt, div_lim;
  logic last_q, done_q, was_held;

  wire hw_raw = ~(hwait_in ^ hwait_pol);
  wire hold = (hwait_en & hw_sync[1]) | cts_sync[1];
  wire gap_due = guard_en & was_held;
  wire [DIV_W-1:0] div_m1 = (baud_div == '0) ? '0 : baud_div - 1'b1;
  wire tick = (baud_cnt == div_lim);
  wire frame_end = tick & (bit_idx == LAST_IDX);

  assign s_ready = (st == S_RDY) & ~hold & ~gap_due;
  wire accept = s_valid & s_ready;
  assign txd = (st == S_SEND) ? sh[0] : 1'b1;
  assign busy = (st != S_OFF);
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_sync  <= 2'b11;
      cts_sync <= 2'b11;
    end else begin
      hw_sync  <= {hw_sync[0], hw_raw};
      cts_sync <= {cts_sync[0], cts_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      sh       <= '1;
      bit_idx  <= '0;
      baud_cnt <= '0;
      div_lim  <= '0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      was_held <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          if (start) begin
            st       <= S_RDY;
            done_q   <= 1'b0;
            was_held <= 1'b0;
          end
        end
        S_RDY: begin
          div_lim  <= div_m1;
          baud_cnt <= '0;
          bit_idx  <= '0;
          if (hold) begin
            was_held <= 1'b1;
          end else if (gap_due) begin
            was_held <= 1'b0;
            st       <= S_GAP;
          end else if (accept) begin
            sh     <= {1'b1, s_data, 1'b0};
            last_q <= s_last;
            st     <= S_SEND;
          end
        end
        S_SEND: begin
          if (tick) begin
            baud_cnt <= '0;
            if (bit_idx == LAST_IDX) begin
              st     <= last_q ? S_OFF : S_RDY;
              done_q <= last_q;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              sh      <= {1'b1, sh[FRAME_BITS-1:1]};
            end
          end else begin
            baud_cnt <= baud_cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (tick) begin
            baud_cnt <= '0;
            if (bit_idx == LAST_IDX) st <= S_RDY;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            baud_cnt <= baud_cnt + 1'b1;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st == S_SEND && !txd));
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && $past(st == S_SEND) && !$past(tick)) |-> $stable(txd));
  p_frame_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && frame_end && !last_q) |=> (st == S_RDY && txd));
  p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && txd));
  p_no_start_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDY && hold) |=> (st != S_SEND));
  p_gap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> (txd && !s_ready));
endmodule

// File: tb/boot_stream_tx_tb.sv
module boot_stream_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic [15:0] baud_div = 16'd4;
  logic hwait_en = 1'b1, hwait_pol = 1'b1, hwait_in = 1'b0, cts_n = 1'b0, guard_en = 1'b0;
  logic busy, done, s_ready, txd;

  boot_stream_tx #(.DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .baud_div(baud_div), .hwait_en(hwait_en), .hwait_pol(hwait_pol),
    .hwait_in(hwait_in), .cts_n(cts_n), .guard_en(guard_en), .txd(txd));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int cur_div = 4;
  logic [7:0] rx_q [0:63];
  int rx_t [0:63];
  int rx_cnt = 0, rx_starts = 0;

  localparam logic [23:0] VEC [0:5] = '{24'h0001A5, 24'h00023C, 24'h000301,
                                        24'h000480, 24'h0007FF, 24'h000500};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin : rx_mon
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        if (rx_starts < 64) rx_t[rx_starts] = cyc;
        rx_starts++;
        repeat ((cur_div - 1) / 2) @(negedge clk);
        check(txd === 1'b0, "R2 start bit", txd, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (cur_div) @(negedge clk);
          b[k] = txd;
        end
        repeat (cur_div) @(negedge clk);
        check(txd === 1'b1, "R2 stop bit", txd, 1);
        if (rx_cnt < 64) rx_q[rx_cnt] = b;
        rx_cnt++;
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + 37 * i);
  endfunction

  task automatic start_pulse();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic last);
    @(negedge clk);
    s_data = d; s_last = last; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic push_seq(input int n, input int seed);
    for (int i = 0; i < n; i++) push(pat(seed, i), i == n - 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    baud_div = 16'(d); cur_div = d;
  endtask

  initial begin : main
    int base, t_rel, gap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R1 txd idle", txd, 1);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(done === 1'b0, "R1 done", done, 0);
    check(s_ready === 1'b0, "R1 s_ready", s_ready, 0);

    for (int v = 0; v < 6; v++) begin
      set_div(int'(VEC[v][23:8]));
      start_pulse();
      check(busy === 1'b1, "R3 busy after start", busy, 1);
      push(VEC[v][7:0], 1'b1);
      wait_done();
      check(rx_q[rx_cnt-1] == VEC[v][7:0], "R2 byte", rx_q[rx_cnt-1], VEC[v][7:0]);
      check(busy === 1'b0 && done === 1'b1, "R3 done after last", {busy, done}, 1);
    end

    set_div(2);
    base = rx_cnt;
    start_pulse();
    fork push_seq(4, 17); join_none
    while (rx_starts < base + 1) @(negedge clk);
    check(s_ready === 1'b0, "R4 s_ready low while shifting", s_ready, 0);
    while (rx_cnt < base + 2) @(negedge clk);
    start_pulse();
    check(busy === 1'b1 && done === 1'b0, "R3 start ignored mid-session", {busy, done}, 2);
    wait_done();
    for (int i = 0; i < 4; i++)
      check(rx_q[base+i] == pat(17, i), "R2 stream byte", rx_q[base+i], pat(17, i));
    for (int i = 0; i < 3; i++)
      check(rx_t[base+i+1] - rx_t[base+i] == 21, "R2 start spacing",
            rx_t[base+i+1] - rx_t[base+i], 21);

    set_div(4);
    base = rx_cnt;
    start_pulse();
    fork push_seq(3, 90); join_none
    while (rx_starts < base + 2) @(negedge clk);
    repeat (6) @(negedge clk);
    hwait_in = 1'b1;
    while (rx_cnt < base + 2) @(negedge clk);
    check(rx_q[base+1] == pat(90, 1), "R5 word completes under host-wait", rx_q[base+1], pat(90, 1));
    repeat (120) @(negedge clk);
    check(rx_starts == base + 2, "R5 no start while host-wait", rx_starts, base + 2);
    check(s_ready === 1'b0, "R4 s_ready low while paused", s_ready, 0);
    hwait_in = 1'b0;
    wait_done();
    check(rx_q[base+2] == pat(90, 2), "R5 resume byte", rx_q[base+2], pat(90, 2));

    hwait_pol = 1'b0;
    hwait_in = 1'b0;
    base = rx_starts;
    start_pulse();
    fork push_seq(1, 201); join_none
    repeat (100) @(negedge clk);
    check(rx_starts == base && busy === 1'b1, "R6 low level active when pol=0", rx_starts, base);
    hwait_in = 1'b1;
    wait_done();
    check(rx_q[rx_cnt-1] == pat(201, 0), "R6 sent after inactive", rx_q[rx_cnt-1], pat(201, 0));
    hwait_pol = 1'b1;
    hwait_in = 1'b0;

    hwait_en = 1'b0;
    hwait_in = 1'b1;
    base = rx_cnt;
    start_pulse();
    fork push_seq(1, 66); join_none
    repeat (150) @(negedge clk);
    check(rx_cnt == base + 1 && done === 1'b1, "R7 host-wait disabled", rx_cnt, base + 1);
    check(rx_q[base] == pat(66, 0), "R7 byte", rx_q[base], pat(66, 0));
    hwait_in = 1'b0;
    hwait_en = 1'b1;

    base = rx_cnt;
    start_pulse();
    fork push_seq(2, 140); join_none
    while (rx_starts < base + 1) @(negedge clk);
    repeat (9) @(negedge clk);
    cts_n = 1'b1;
    while (rx_cnt < base + 1) @(negedge clk);
    check(rx_q[base] == pat(140, 0), "R8 word completes under CTS", rx_q[base], pat(140, 0));
    repeat (120) @(negedge clk);
    check(rx_starts == base + 1 && txd === 1'b1, "R8 line idle while CTS high", rx_starts, base + 1);
    cts_n = 1'b0;
    wait_done();
    check(rx_q[base+1] == pat(140, 1), "R8 resume byte", rx_q[base+1], pat(140, 1));

    set_div(3);
    for (int g = 0; g < 2; g++) begin
      guard_en = 1'(g);
      cts_n = 1'b1;
      base = rx_starts;
      start_pulse();
      fork push_seq(1, 50 + g); join_none
      repeat (20) @(negedge clk);
      cts_n = 1'b0;
      t_rel = cyc;
      wait_done();
      gap = rx_t[base] - t_rel;
      if (g == 1) check(gap >= 30, "R9 guard gap present", gap, 30);
      else check(gap >= 2 && gap < 30, "R9 no guard gap", gap, 5);
      check(rx_q[rx_cnt-1] == pat(50 + g, 0), "R9 byte", rx_q[rx_cnt-1], pat(50 + g, 0));
    end
    guard_en = 1'b0;

    summary();
  end
endmodule